// File: doc/BRIEF.md
# Programmable Raster Timing Generator for Parallel Panels

This block turns a handful of packed configuration words into the raster timing of a parallel RGB display. A free-running divider makes a pixel-rate enable from the system clock. Each time that enable fires, a pixel counter and a line counter advance through four regions in a fixed order: sync, back porch, active, front porch. Horizontal sync, vertical sync and data enable are decoded from where the counters stand. Each of these outputs has its own polarity control. A slowly alternating bias output can be used to keep charge from building up on monochrome glass.

Software reaches the block only through a write port. The port writes seven word registers: horizontal timing, vertical timing, clock and polarity, control, next frame base, interrupt enable and interrupt clear. A base address written at any point is held as pending. When the raster wraps back to the first sync line, the pending address is copied to the active base output, and a status bit records that the copy happened. The masked interrupt line is that status bit qualified by its enable bit.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset, the pixel enable, the sync and data enable outputs, the bias output, both counters, the active base and both interrupt outputs are all 0.
- R2: While the run bit (control register 3, bit 0) is 0, both counters are held at 0 and the pixel enable stays 0. Once run is set, the first pixel enable comes d-1 cycles after the write edge, where d is the divisor.
- R3: Horizontal register 0 holds four fields: sync width minus one in [15:8], back porch minus one in [31:24], active pixels divided by 16 minus one in [7:2], and front porch minus one in [23:16]. A line is made of these four regions in the order sync, back porch, active, front porch. The pixel counter counts 0 up to the line total minus one.
- R4: In register 2, bits {[31:27],[4:0]} form a 10-bit divider value p, and the pixel enable pulses once every p+2 clocks. When bit 26 is 1, the divider value is ignored and the enable is high on every clock.
- R5: Vertical register 1 holds four fields: active lines minus one in [9:0], sync lines minus one in [15:10], front porch lines in [23:16] and back porch lines in [31:24]. Both porch fields are exact counts and may be zero. A frame is sync, back porch, active, front porch, in that order.
- R6: Data enable is asserted only when both the pixel and line counters are inside their active regions.
- R7: In register 2, bit 12 inverts hsync, bit 11 inverts vsync and bit 14 makes data enable active low. Bit 13 is reported on the launch-edge output while power is on.
- R8: While the power bit (register 3, bit 1) is 0, hsync, vsync and data enable sit at their inactive levels and the bias output is 0. The counters still run.
- R9: With the bias count a = register 2 bits [10:6], the bias output inverts once every a+1 completed lines after run is set.
- R10: A write to register 4 stores a pending base with bits [1:0] forced to 0. On the pixel enable that ends the last pixel of a frame, the pending base becomes the active base and the status bit is set. The old base stays visible until then.
- R11: The interrupt output equals the status bit ANDed with the enable bit in register 5, bit 0.
- R12: Writing 1 to register 6 bit 0 clears the status bit. Writing 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word index |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per R7 |
| vsync_o | output | 1 | Vertical sync, polarity per R7 |
| de_o | output | 1 | Data enable, polarity per R7 |
| pclk_en_o | output | 1 | Pixel-rate enable |
| launch_fall_o | output | 1 | Data launch on falling pixel edge |
| ac_bias_o | output | 1 | Alternating bias level |
| hcount_o | output | 12 | Pixel position within line |
| vcount_o | output | 12 | Line position within frame |
| base_addr_o | output | 32 | Active frame base address |
| irq_raw_o | output | 1 | Base-taken status bit |
| irq_o | output | 1 | Masked interrupt |

## Verification
A register write takes effect at the capture edge, so the first pixel enable after run is set comes d-1 cycles later. The counters move on the edge that carries the enable. The sync, data enable and bias outputs follow the counters with no further register. The bench therefore samples on the falling clock edge of every cycle that shows the enable, and derives the expected position from how many enables it has seen. The base and status update on the edge of the enable for the frame's last pixel. Because the next enable comes at least one cycle later, they are checked against that next position, which gives them one cycle of margin.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int REGW = 32;
  localparam int AW   = 3;
  localparam int HCW  = 12;
  localparam int VCW  = 12;
  localparam int PCDW = 10;
  localparam int DIVW = PCDW + 1;
  localparam int ACBW = 5;

  localparam logic [AW-1:0] ADR_HTIM = AW'(0);
  localparam logic [AW-1:0] ADR_VTIM = AW'(1);
  localparam logic [AW-1:0] ADR_PTIM = AW'(2);
  localparam logic [AW-1:0] ADR_CTRL = AW'(3);
  localparam logic [AW-1:0] ADR_BASE = AW'(4);
  localparam logic [AW-1:0] ADR_IEN  = AW'(5);
  localparam logic [AW-1:0] ADR_ICLR = AW'(6);

  typedef struct packed {
    logic [5:0] ppl;
    logic [7:0] hsw;
    logic [7:0] hfp;
    logic [7:0] hbp;
  } htim_t;

  typedef struct packed {
    logic [9:0] lpp;
    logic [5:0] vsw;
    logic [7:0] vfp;
    logic [7:0] vbp;
  } vtim_t;

  typedef struct packed {
    logic [PCDW-1:0] pcd;
    logic            bypass;
    logic [ACBW-1:0] acb;
    logic            inv_hs;
    logic            inv_vs;
    logic            inv_de;
    logic            launch_fall;
  } ptim_t;

  // horizontal boundaries, all in pixel ticks from line start
  function automatic logic [HCW-1:0] h_sync_end(logic [7:0] hsw);
    return HCW'(hsw) + HCW'(1);
  endfunction

  function automatic logic [HCW-1:0] h_act_first(logic [7:0] hsw, logic [7:0] hbp);
    return HCW'(hsw) + HCW'(hbp) + HCW'(2);
  endfunction

  function automatic logic [HCW-1:0] h_act_end(logic [HCW-1:0] first, logic [5:0] ppl);
    return first + ((HCW'(ppl) + HCW'(1)) << 4);
  endfunction

  function automatic logic [HCW-1:0] h_total(logic [HCW-1:0] act_end, logic [7:0] hfp);
    return act_end + HCW'(hfp) + HCW'(1);
  endfunction

  // vertical boundaries, porches are exact counts
  function automatic logic [VCW-1:0] v_sync_end(logic [5:0] vsw);
    return VCW'(vsw) + VCW'(1);
  endfunction

  function automatic logic [VCW-1:0] v_act_first(logic [VCW-1:0] sync_end, logic [7:0] vbp);
    return sync_end + VCW'(vbp);
  endfunction

  function automatic logic [VCW-1:0] v_act_end(logic [VCW-1:0] first, logic [9:0] lpp);
    return first + VCW'(lpp) + VCW'(1);
  endfunction

  function automatic logic [VCW-1:0] v_total(logic [VCW-1:0] act_end, logic [7:0] vfp);
    return act_end + VCW'(vfp);
  endfunction

  function automatic logic [DIVW-1:0] pclk_divisor(logic byp, logic [PCDW-1:0] pcd);
    return byp ? DIVW'(1) : (DIVW'(pcd) + DIVW'(2));
  endfunction
endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
  import lcd_tg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [REGW-1:0] wr_data,
  output htim_t           htim,
  output vtim_t           vtim,
  output ptim_t           ptim,
  output logic            run,
  output logic            pwr,
  output logic            base_wr,
  output logic            ien_wr,
  output logic            clr_wr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htim <= '0;
      vtim <= '0;
      ptim <= '0;
      run  <= 1'b0;
      pwr  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_HTIM: htim <= '{ppl: wr_data[7:2], hsw: wr_data[15:8],
                            hfp: wr_data[23:16], hbp: wr_data[31:24]};
        ADR_VTIM: vtim <= '{lpp: wr_data[9:0], vsw: wr_data[15:10],
                            vfp: wr_data[23:16], vbp: wr_data[31:24]};
        ADR_PTIM: ptim <= '{pcd: {wr_data[31:27], wr_data[4:0]},
                            bypass: wr_data[26], acb: wr_data[10:6],
                            inv_hs: wr_data[12], inv_vs: wr_data[11],
                            inv_de: wr_data[14], launch_fall: wr_data[13]};
        ADR_CTRL: begin
          run <= wr_data[0];
          pwr <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  assign base_wr = wr_en && (wr_addr == ADR_BASE);
  assign ien_wr  = wr_en && (wr_addr == ADR_IEN);
  assign clr_wr  = wr_en && (wr_addr == ADR_ICLR);
endmodule

// File: rtl/lcd_tg_pclk.sv
module lcd_tg_pclk
  import lcd_tg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            bypass,
  input  logic [PCDW-1:0] pcd,
  output logic            tick
);
  logic [DIVW-1:0] divisor;
  logic [DIVW-1:0] cnt_q;
  logic            period_done;

  assign divisor     = pclk_divisor(bypass, pcd);
  assign period_done = (cnt_q >= divisor - DIVW'(1));
  assign tick        = run && period_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run)        cnt_q <= '0;
    else if (period_done) cnt_q <= '0;
    else                  cnt_q <= cnt_q + DIVW'(1);
  end

  // R4: with a real divider two enables are never adjacent
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass) |=> (!tick || bypass));
endmodule

// File: rtl/lcd_tg_raster.sv
module lcd_tg_raster
  import lcd_tg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  htim_t           htim,
  input  vtim_t           vtim,
  input  logic [ACBW-1:0] acb,
  output logic [HCW-1:0]  hcnt,
  output logic [VCW-1:0]  vcnt,
  output logic            in_hs,
  output logic            in_vs,
  output logic            in_de,
  output logic            line_end,
  output logic            frame_end,
  output logic            acb_lvl
);
  logic [HCW-1:0]  h_first, h_end, h_tot;
  logic [VCW-1:0]  v_sync, v_first, v_end, v_tot;
  logic            h_last, v_last;
  logic [ACBW-1:0] acb_cnt;

  assign h_first = h_act_first(htim.hsw, htim.hbp);
  assign h_end   = h_act_end(h_first, htim.ppl);
  assign h_tot   = h_total(h_end, htim.hfp);
  assign v_sync  = v_sync_end(vtim.vsw);
  assign v_first = v_act_first(v_sync, vtim.vbp);
  assign v_end   = v_act_end(v_first, vtim.lpp);
  assign v_tot   = v_total(v_end, vtim.vfp);

  assign h_last    = (hcnt >= h_tot - HCW'(1));
  assign v_last    = (vcnt >= v_tot - VCW'(1));
  assign line_end  = run && tick && h_last;
  assign frame_end = line_end && v_last;

  assign in_hs = (hcnt < h_sync_end(htim.hsw));
  assign in_vs = (vcnt < v_sync);
  assign in_de = (hcnt >= h_first) && (hcnt < h_end) &&
                 (vcnt >= v_first) && (vcnt < v_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '0;
      vcnt    <= '0;
      acb_cnt <= '0;
      acb_lvl <= 1'b0;
    end else if (!run) begin
      hcnt    <= '0;
      vcnt    <= '0;
      acb_cnt <= '0;
      acb_lvl <= 1'b0;
    end else if (tick) begin
      if (h_last) begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + VCW'(1);
        if (acb_cnt >= acb) begin
          acb_cnt <= '0;
          acb_lvl <= ~acb_lvl;
        end else begin
          acb_cnt <= acb_cnt + ACBW'(1);
        end
      end else begin
        hcnt <= hcnt + HCW'(1);
      end
    end
  end

  // R2: counters are cleared while stopped
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0 && vcnt == '0));
  // R3: each line restarts at pixel zero
  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));
  // R6: active region never overlaps a sync region
  a_r6_de_not_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    in_de |-> (!in_hs && !in_vs));
  // R9: bias level only changes at the end of a line
  a_r9_bias_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end) |=> $stable(acb_lvl));
endmodule

// File: rtl/lcd_tg_base_irq.sv
module lcd_tg_base_irq
  import lcd_tg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_wr,
  input  logic [REGW-1:2] base_wdata,
  input  logic            ien_wr,
  input  logic            clr_wr,
  input  logic            flag_bit,
  input  logic            frame_end,
  output logic [REGW-1:0] active_base,
  output logic            raw,
  output logic            masked
);
  logic [REGW-1:2] next_q, act_q;
  logic            pend_q, ien_q, raw_q;
  logic            latch;

  assign latch = frame_end && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
      ien_q  <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      if (base_wr) begin
        next_q <= base_wdata;
        pend_q <= 1'b1;
      end else if (latch) begin
        pend_q <= 1'b0;
      end
      if (latch) act_q <= next_q;
      if (latch)                     raw_q <= 1'b1;
      else if (clr_wr && flag_bit)   raw_q <= 1'b0;
      if (ien_wr) ien_q <= flag_bit;
    end
  end

  assign active_base = {act_q, 2'b00};
  assign raw         = raw_q;
  assign masked      = raw_q && ien_q;

  // R10: a base hand-over always raises the status bit
  a_r10_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> raw_q);
  // R10: the active base moves only at a hand-over
  a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(act_q));
  // R12: a one written to the clear register drops the status
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && flag_bit && !latch) |=> !raw_q);
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_tg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [REGW-1:0] wr_data_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            pclk_en_o,
  output logic            launch_fall_o,
  output logic            ac_bias_o,
  output logic [HCW-1:0]  hcount_o,
  output logic [VCW-1:0]  vcount_o,
  output logic [REGW-1:0] base_addr_o,
  output logic            irq_raw_o,
  output logic            irq_o
);
  htim_t htim;
  vtim_t vtim;
  ptim_t ptim;
  logic  run, pwr, base_wr, ien_wr, clr_wr;
  logic  tick, in_hs, in_vs, in_de, line_end, frame_end, acb_lvl;
  logic  drive;

  lcd_tg_cfg u_cfg (
    .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .htim(htim), .vtim(vtim), .ptim(ptim),
    .run(run), .pwr(pwr), .base_wr(base_wr), .ien_wr(ien_wr), .clr_wr(clr_wr)
  );

  lcd_tg_pclk u_pclk (
    .clk(clk_i), .rst_n(rst_ni), .run(run), .bypass(ptim.bypass),
    .pcd(ptim.pcd), .tick(tick)
  );

  lcd_tg_raster u_raster (
    .clk(clk_i), .rst_n(rst_ni), .run(run), .tick(tick), .htim(htim),
    .vtim(vtim), .acb(ptim.acb), .hcnt(hcount_o), .vcnt(vcount_o),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .line_end(line_end),
    .frame_end(frame_end), .acb_lvl(acb_lvl)
  );

  lcd_tg_base_irq u_base_irq (
    .clk(clk_i), .rst_n(rst_ni), .base_wr(base_wr),
    .base_wdata(wr_data_i[REGW-1:2]), .ien_wr(ien_wr), .clr_wr(clr_wr),
    .flag_bit(wr_data_i[0]), .frame_end(frame_end),
    .active_base(base_addr_o), .raw(irq_raw_o), .masked(irq_o)
  );

  assign drive         = pwr && run;
  assign hsync_o       = ptim.inv_hs ^ (drive && in_hs);
  assign vsync_o       = ptim.inv_vs ^ (drive && in_vs);
  assign de_o          = ptim.inv_de ^ (drive && in_de);
  assign ac_bias_o     = drive && acb_lvl;
  assign launch_fall_o = pwr && ptim.launch_fall;
  assign pclk_en_o     = tick;

  // R8: with power off nothing toggles on the panel pins
  a_r8_power_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr |-> (!ac_bias_o && (de_o == ptim.inv_de) && (hsync_o == ptim.inv_hs)));
  // R2: no pixel enable while stopped
  a_r2_no_tick_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !pclk_en_o);
endmodule

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync_o, vsync_o, de_o, pclk_en_o, launch_fall_o, ac_bias_o;
  logic [11:0] hcount_o, vcount_o;
  logic [31:0] base_addr_o;
  logic        irq_raw_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lcd_raster_timer u_lcd_raster_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pclk_en_o(pclk_en_o), .launch_fall_o(launch_fall_o), .ac_bias_o(ac_bias_o),
    .hcount_o(hcount_o), .vcount_o(vcount_o), .base_addr_o(base_addr_o),
    .irq_raw_o(irq_raw_o), .irq_o(irq_o)
  );

  // configuration under test
  int c_ppl, c_hsw, c_hbp, c_hfp, c_lpp, c_vsw, c_vbp, c_vfp;
  int c_pcd, c_byp, c_acb, c_ihs, c_ivs, c_ide, c_fall, c_pwr, c_ien;
  logic [31:0] c_base;
  logic [31:0] exp_base = '0;

  int          t_bad [12];
  bit          t_used[12];
  logic [31:0] t_act [12];
  logic [31:0] t_exp [12];
  string       t_lbl [12];

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic note(input int idx, input logic [31:0] act, input logic [31:0] exp);
    t_used[idx] = 1'b1;
    if (act !== exp) begin
      if (t_bad[idx] == 0) begin
        t_act[idx] = act;
        t_exp[idx] = exp;
      end
      t_bad[idx]++;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic int line_len();
    return (c_hsw + 1) + (c_hbp + 1) + 16 * (c_ppl + 1) + (c_hfp + 1);
  endfunction

  function automatic int frame_lines();
    return (c_vsw + 1) + c_vbp + (c_lpp + 1) + c_vfp;
  endfunction

  function automatic int divisor();
    return c_byp ? 1 : c_pcd + 2;
  endfunction

  task automatic run_cfg();
    int hl, fl, frame, d, total, p, cyc, last;
    logic [31:0] htw, vtw, ptw;
    logic [9:0] pcd10;
    for (int i = 0; i < 12; i++) begin t_bad[i] = 0; t_used[i] = 1'b0; end
    hl = line_len(); fl = frame_lines(); frame = hl * fl; d = divisor();
    total = 2 * frame;
    pcd10 = 10'(c_pcd);
    htw = {8'(c_hbp), 8'(c_hfp), 8'(c_hsw), 6'(c_ppl), 2'b11};
    vtw = {8'(c_vbp), 8'(c_vfp), 6'(c_vsw), 10'(c_lpp)};
    ptw = {pcd10[9:5], 1'(c_byp), 11'b0, 1'(c_ide), 1'(c_fall), 1'(c_ihs),
           1'(c_ivs), 5'(c_acb), 1'b0, pcd10[4:0]};
    wr(3'd3, 32'd0);
    wr(3'd6, 32'd1);
    wr(3'd0, htw);
    wr(3'd1, vtw);
    wr(3'd2, ptw);
    wr(3'd5, 32'(c_ien));
    wr(3'd4, c_base);
    wr(3'd3, {30'd0, 1'(c_pwr), 1'b1});
    p = 0; cyc = 0; last = -1;
    while (p < total && cyc < 60000) begin
      if (pclk_en_o) begin
        int h, ln, v;
        bit act_h, act_v;
        h = p % hl; ln = p / hl; v = ln % fl;
        act_h = (h >= c_hsw + c_hbp + 2) && (h < c_hsw + c_hbp + 2 + 16 * (c_ppl + 1));
        act_v = (v >= c_vsw + 1 + c_vbp) && (v < c_vsw + 1 + c_vbp + c_lpp + 1);
        note(0, 32'(hcount_o), 32'(h));                          // R3
        note(2, 32'(vcount_o), 32'(v));                          // R5
        note(5, 32'(cyc), 32'((last < 0) ? d - 1 : last + d));   // R4 / R2
        note(6, 32'(launch_fall_o), 32'(c_pwr & c_fall));        // R7
        if (c_pwr != 0) begin
          note(1, 32'(hsync_o), 32'(c_ihs ^ int'(h <= c_hsw)));          // R3 R7
          note(3, 32'(vsync_o), 32'(c_ivs ^ int'(v <= c_vsw)));          // R5 R7
          note(4, 32'(de_o), 32'(c_ide ^ int'(act_h && act_v)));         // R6 R7
          note(7, 32'(ac_bias_o), 32'((ln / (c_acb + 1)) % 2));          // R9
        end else begin
          note(11, {29'd0, hsync_o, vsync_o, de_o}, {29'd0, 1'(c_ihs), 1'(c_ivs), 1'(c_ide)}); // R8
          note(11, 32'(ac_bias_o), 32'd0);                                 // R8
        end
        if (p < frame) begin
          note(8, base_addr_o, exp_base);                        // R10 old base kept
          note(9, 32'(irq_raw_o), 32'd0);                        // R10
          note(10, 32'(irq_o), 32'd0);                           // R11
        end else begin
          note(8, base_addr_o, c_base & ~32'd3);                 // R10 new base
          note(9, 32'(irq_raw_o), 32'd1);                        // R10
          note(10, 32'(irq_o), 32'(c_ien));                      // R11
        end
        last = cyc;
        p++;
      end
      cyc++;
      @(negedge clk);
    end
    chk("R2 run completes", p == total, 32'(p), 32'(total));
    for (int i = 0; i < 12; i++)
      if (t_used[i]) chk(t_lbl[i], t_bad[i] == 0, t_act[i], t_exp[i]);
    exp_base = c_base & ~32'd3;
    // R12: a zero written to the clear register is ignored
    wr(3'd6, 32'd0);
    chk("R12 clear with zero keeps status", irq_raw_o == 1'b1, 32'(irq_raw_o), 32'd1);
    wr(3'd6, 32'd1);
    chk("R12 clear with one drops status", irq_raw_o == 1'b0, 32'(irq_raw_o), 32'd0);
    chk("R11 irq follows cleared status", irq_o == 1'b0, 32'(irq_o), 32'd0);
    // R2: stopping holds counters at zero
    wr(3'd3, 32'd0);
    @(negedge clk);
    chk("R2 stopped counters", {hcount_o, vcount_o} == '0, 32'({hcount_o, vcount_o}), 32'd0);
    chk("R2 stopped enable", pclk_en_o == 1'b0, 32'(pclk_en_o), 32'd0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    t_lbl[0] = "R3 pixel counter";   t_lbl[1] = "R3 hsync";
    t_lbl[2] = "R5 line counter";    t_lbl[3] = "R5 vsync";
    t_lbl[4] = "R6 data enable";     t_lbl[5] = "R4 enable spacing";
    t_lbl[6] = "R7 launch edge";     t_lbl[7] = "R9 bias toggle";
    t_lbl[8] = "R10 active base";    t_lbl[9] = "R10 status bit";
    t_lbl[10] = "R11 masked irq";    t_lbl[11] = "R8 power gating";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset panel pins", {hsync_o, vsync_o, de_o, ac_bias_o, pclk_en_o} == 5'b0,
        32'({hsync_o, vsync_o, de_o, ac_bias_o, pclk_en_o}), 32'd0);
    chk("R1 reset counters", {hcount_o, vcount_o} == '0, 32'({hcount_o, vcount_o}), 32'd0);
    chk("R1 reset base and irq", {base_addr_o, irq_raw_o, irq_o} == '0,
        base_addr_o | 32'({irq_raw_o, irq_o}), 32'd0);

    for (int k = 0; k < 8; k++) begin
      c_ppl = int'($urandom_range(1, 0)); c_hsw = int'($urandom_range(3, 0));
      c_hbp = int'($urandom_range(3, 0)); c_hfp = int'($urandom_range(3, 0));
      c_lpp = int'($urandom_range(5, 0)); c_vsw = int'($urandom_range(2, 0));
      c_vbp = int'($urandom_range(2, 0)); c_vfp = int'($urandom_range(2, 0));
      c_pcd = int'($urandom_range(3, 0)); c_byp = int'($urandom_range(3, 0) == 0);
      c_acb = int'($urandom_range(3, 0)); c_ihs = int'($urandom_range(1, 0));
      c_ivs = int'($urandom_range(1, 0)); c_ide = int'($urandom_range(1, 0));
      c_fall = int'($urandom_range(1, 0)); c_pwr = 1;
      c_ien = int'($urandom_range(1, 0)); c_base = $urandom();
      if (k == 0) begin
        // split divider field: only the high part is set
        c_ppl = 0; c_hsw = 0; c_hbp = 0; c_hfp = 0;
        c_lpp = 0; c_vsw = 0; c_vbp = 0; c_vfp = 0;
        c_pcd = 32; c_byp = 0; c_ien = 1; c_base = 32'h1234_5677;
      end else if (k == 1) begin
        // power off with every inversion set
        c_pwr = 0; c_ihs = 1; c_ivs = 1; c_ide = 1; c_fall = 1; c_ien = 0;
      end else if (k == 2) begin
        // bypass overrides a nonzero divider field
        c_byp = 1; c_pcd = 3; c_acb = 0;
      end
      run_cfg();
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule